// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width modulator. It divides the system clock with a two-stage prescaler into count ticks. On each tick it advances a 16-bit counter in one of four modes: up, down, up-down or frozen. A single write port loads four registers: a control word, the period, and two compare levels. The block reports the counter value and the present counting direction. Each step that lands on zero, on the period, or on a compare level while counting upward raises a one-cycle event strobe.

The period can be written in two ways. It can take effect at once, or it can be staged in a shadow copy that becomes active only when the counter next reaches zero. The run field sets when counting stops. It can run without limit, stop after one more step, or stop at the end of the current full cycle. Downstream waveform logic uses the strobes and the direction flag to set and clear its outputs.

Top module: `ptb_time_base`

## Requirements
- R1: After reset the counter reads 0, the direction flag is 0, all four strobes are low, the mode field holds 11 (frozen) and the run field holds 00, so the counter does not move.
- R2: In up mode (control bits 1:0 = 00) the counter steps 0,1,…,P and then returns to 0 on the next tick (also at once if above P). The zero strobe pulses for one cycle on the step to 0, the period strobe on the step to P, and the direction flag is 0.
- R3: In down mode (bits 1:0 = 01) the counter steps down to 0 and then reloads P. The direction flag reads 1 and no compare strobe fires.
- R4: In up-down mode (bits 1:0 = 10) the counter rises to P, turns and falls to 0, then turns and rises again. The direction flag is 1 exactly while the counter is falling.
- R5: With bits 1:0 = 11 the counter and direction hold their values and no strobe fires, even while the run field allows counting.
- R6: A tick occurs every (2^D)·H clock cycles. D is control bits 12:10. H is 1 when control bits 9:7 are zero and twice their value otherwise. The counter changes only on ticks.
- R7: With control bit 3 = 0, a period write goes to a shadow copy. The active period changes only on the step at which the counter reaches 0, and then takes the shadow value.
- R8: With control bit 3 = 1, a period write replaces the active period at once.
- R9: Run field (bits 15:14) = 00: after the field is written, the counter makes exactly one more step and then holds.
- R10: Run field = 01: counting continues until a step brings the counter to 0, then it holds. Run field 1x counts without stopping.
- R11: The compare-A and compare-B strobes pulse when a step brings the counter to the matching compare value while counting upward. They never pulse on a downward step.
- R12: The write select chooses the target: 0 control word, 1 period, 2 compare A, 3 compare B. A write takes effect at the clock edge where the write enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 period, 2 compare A, 3 compare B) |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Present counter value |
| dir_down | output | 1 | 1 while counting downward |
| ev_zero | output | 1 | Step reached zero |
| ev_period | output | 1 | Step reached the active period |
| ev_cmpa_up | output | 1 | Upward step reached compare A |
| ev_cmpb_up | output | 1 | Upward step reached compare B |

## Verification
A wrong direction bit or a wrong halted state shows up at the very next tick, as a count that moves the wrong way or fails to move. The bench therefore compares every cycle of each scenario against a sequence predicted from the requirements. A stale or early-loaded active period is hidden until the counter wraps, which can take a whole period. The shadow-load scenario runs through at least two wraps so that the changed wrap point becomes visible. A prescaler phase error appears as ticks spaced by the wrong number of cycles, so strobes are also checked to stay low on the cycles between ticks.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    localparam int CTRL_W = 16;
    localparam int PS_W   = 11;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT_NEXT = 2'b00,
        RUN_HALT_WRAP = 2'b01,
        RUN_FREE      = 2'b10,
        RUN_FREE_ALT  = 2'b11
    } run_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CMPA   = 2'd2,
        SEL_CMPB   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        run_e      run;
        logic [2:0] pow2_div;
        logic [2:0] hs_div;
        logic      imm_load;
        cnt_mode_e mode;
    } tb_ctrl_t;

    typedef struct packed {
        logic zero;
        logic period;
        logic cmpa_up;
        logic cmpb_up;
    } tb_events_t;

    localparam tb_ctrl_t CTRL_RESET = '{
        run:      RUN_HALT_NEXT,
        pow2_div: 3'd0,
        hs_div:   3'd0,
        imm_load: 1'b0,
        mode:     MODE_HOLD
    };

    function automatic tb_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        tb_ctrl_t c;
        c.run      = run_e'(w[15:14]);
        c.pow2_div = w[12:10];
        c.hs_div   = w[9:7];
        c.imm_load = w[3];
        c.mode     = cnt_mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [PS_W-1:0] prescale_ratio(input logic [2:0] p2,
                                                       input logic [2:0] hs);
        logic [PS_W-1:0] base;
        logic [PS_W-1:0] mult;
        base = PS_W'(1) << p2;
        mult = (hs == 3'd0) ? PS_W'(1) : PS_W'({hs, 1'b0});
        return PS_W'(base * mult);
    endfunction

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  reg_sel_e         sel_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             zero_load_i,
    output tb_ctrl_t         ctrl_o,
    output logic [CNT_W-1:0] prd_o,
    output logic [CNT_W-1:0] cmpa_o,
    output logic [CNT_W-1:0] cmpb_o
);

    tb_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] prd_shd_q;
    logic [CNT_W-1:0] prd_act_q;
    logic [CNT_W-1:0] cmpa_q;
    logic [CNT_W-1:0] cmpb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            prd_shd_q <= '0;
            prd_act_q <= '0;
            cmpa_q    <= '0;
            cmpb_q    <= '0;
        end else begin
            if (we_i && sel_i == SEL_CTRL)
                ctrl_q <= unpack_ctrl(data_i[CTRL_W-1:0]);
            if (we_i && sel_i == SEL_CMPA)
                cmpa_q <= data_i;
            if (we_i && sel_i == SEL_CMPB)
                cmpb_q <= data_i;
            if (we_i && sel_i == SEL_PERIOD) begin
                prd_shd_q <= data_i;
                if (ctrl_q.imm_load)
                    prd_act_q <= data_i;
                else if (zero_load_i)
                    prd_act_q <= prd_shd_q;
            end else if (zero_load_i) begin
                prd_act_q <= prd_shd_q;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign prd_o  = prd_act_q;
    assign cmpa_o = cmpa_q;
    assign cmpb_o = cmpb_q;

    AST_ACTIVE_PRD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!zero_load_i && !(we_i && sel_i == SEL_PERIOD)) |=> $stable(prd_act_q)); // R7

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
    import ptb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PS_W-1:0] ratio_i,
    output logic            tick_o
);

    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] ratio_m1;

    assign ratio_m1 = ratio_i - PS_W'(1);
    assign tick_o   = (pre_q >= ratio_m1);

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= '0;
        else if (tick_o)
            pre_q <= '0;
        else
            pre_q <= pre_q + PS_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick_o && ratio_m1 != '0) |=> (!tick_o || ratio_m1 == '0)); // R6

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  cnt_mode_e        mode_i,
    input  run_e             run_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic [CNT_W-1:0] cmpa_i,
    input  logic [CNT_W-1:0] cmpb_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output tb_events_t       evt_o,
    output logic             zero_load_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             dn_q;
    logic             nxt_dn;
    logic             halted_q;
    logic             running;
    logic             step;
    logic             up_step;
    tb_events_t       evt_q;

    assign running = run_i[1] | ~halted_q;
    assign step    = tick_i & running & (mode_i != MODE_HOLD);
    assign up_step = (mode_i == MODE_UP) | ((mode_i == MODE_UPDN) & ~nxt_dn);

    always_comb begin
        nxt    = cnt_q;
        nxt_dn = dn_q;
        unique case (mode_i)
            MODE_UP: begin
                nxt_dn = 1'b0;
                nxt    = (cnt_q >= prd_i) ? '0 : cnt_q + CNT_W'(1);
            end
            MODE_DOWN: begin
                nxt_dn = 1'b1;
                nxt    = (cnt_q == '0) ? prd_i : cnt_q - CNT_W'(1);
            end
            MODE_UPDN: begin
                if (!dn_q) begin
                    if (cnt_q >= prd_i) begin
                        nxt_dn = 1'b1;
                        nxt    = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
                    end else begin
                        nxt = cnt_q + CNT_W'(1);
                    end
                end else begin
                    if (cnt_q == '0) begin
                        nxt_dn = 1'b0;
                        nxt    = (prd_i == '0) ? '0 : CNT_W'(1);
                    end else begin
                        nxt = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: begin
                nxt    = cnt_q;
                nxt_dn = dn_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            dn_q     <= 1'b0;
            halted_q <= 1'b1;
            evt_q    <= '0;
        end else begin
            evt_q <= '0;
            if (step) begin
                cnt_q         <= nxt;
                dn_q          <= nxt_dn;
                evt_q.zero    <= (nxt == '0);
                evt_q.period  <= (nxt == prd_i);
                evt_q.cmpa_up <= up_step & (nxt == cmpa_i);
                evt_q.cmpb_up <= up_step & (nxt == cmpb_i);
            end
            if (run_i[1])
                halted_q <= 1'b0;
            else if (step && (run_i == RUN_HALT_NEXT || nxt == '0))
                halted_q <= 1'b1;
        end
    end

    assign cnt_o       = cnt_q;
    assign dir_down_o  = dn_q;
    assign evt_o       = evt_q;
    assign zero_load_o = step & (nxt == '0);

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_HOLD) |=> $stable(cnt_q)); // R5

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (rst)
        (step && mode_i == MODE_DOWN) |=> dn_q); // R3

    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (step && run_i == RUN_HALT_NEXT) |=> (!step || run_i[1])); // R9

endmodule

// File: rtl/ptb_time_base.sv
module ptb_time_base
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             ev_zero,
    output logic             ev_period,
    output logic             ev_cmpa_up,
    output logic             ev_cmpb_up
);

    tb_ctrl_t         ctrl;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cmpa;
    logic [CNT_W-1:0] cmpb;
    logic [PS_W-1:0]  ratio;
    logic             tick;
    logic             zero_load;
    tb_events_t       evt;

    ptb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we_i        (wr_en),
        .sel_i       (reg_sel_e'(wr_sel)),
        .data_i      (wr_data),
        .zero_load_i (zero_load),
        .ctrl_o      (ctrl),
        .prd_o       (prd_act),
        .cmpa_o      (cmpa),
        .cmpb_o      (cmpb)
    );

    assign ratio = prescale_ratio(ctrl.pow2_div, ctrl.hs_div);

    ptb_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (ratio),
        .tick_o  (tick)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .mode_i      (ctrl.mode),
        .run_i       (ctrl.run),
        .prd_i       (prd_act),
        .cmpa_i      (cmpa),
        .cmpb_i      (cmpb),
        .cnt_o       (count),
        .dir_down_o  (dir_down),
        .evt_o       (evt),
        .zero_load_o (zero_load)
    );

    assign ev_zero    = evt.zero;
    assign ev_period  = evt.period;
    assign ev_cmpa_up = evt.cmpa_up;
    assign ev_cmpb_up = evt.cmpb_up;

    AST_ZERO_EVT: assert property (@(posedge clk) disable iff (rst)
        ev_zero |-> (count == '0)); // R2

    AST_PRD_EVT: assert property (@(posedge clk) disable iff (rst)
        (ev_period && !$past(wr_en)) |-> (count == prd_act)); // R2

    AST_CMP_UP_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ev_cmpa_up || ev_cmpb_up) |-> !dir_down); // R11

endmodule

// File: tb/ptb_time_base_tb.sv
module ptb_time_base_tb;

    localparam int CNT_W = 16;

    typedef struct {
        int    cnt;
        bit    dir;
        bit [3:0] ev;
        bit    chk_dir;
        bit    chk_ev;
        string req;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count;
    logic             dir_down;
    logic             ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up;

    item_t q[$];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ptb_time_base #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .count      (count),
        .dir_down   (dir_down),
        .ev_zero    (ev_zero),
        .ev_period  (ev_period),
        .ev_cmpa_up (ev_cmpa_up),
        .ev_cmpb_up (ev_cmpb_up)
    );

    // monitor: pops one expected item per cycle
    always begin
        @(negedge clk);
        #1;
        if (q.size() > 0) begin
            item_t it;
            bit bad;
            bit [3:0] evs;
            it  = q.pop_front();
            evs = {ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up};
            bad = (int'(count) != it.cnt);
            if (it.chk_dir && dir_down != it.dir) bad = 1'b1;
            if (it.chk_ev && evs != it.ev) bad = 1'b1;
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s: count=%0d exp %0d dir=%0b exp %0b ev=%b exp %b",
                         it.req, count, it.cnt, dir_down, it.dir, evs, it.ev);
            end
        end
    end

    task automatic push(input int c, input bit d, input bit [3:0] e,
                        input bit cd, input bit ce, input string r);
        item_t it;
        it.cnt = c; it.dir = d; it.ev = e; it.chk_dir = cd; it.chk_ev = ce; it.req = r;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit [3:0] exp_ev(input int v, input int prd, input bit up);
        return {v == 0, v == prd, up && v == 2, up && v == 3};
    endfunction

    task automatic poll_change();
        int prev;
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            prev = int'(count);
            @(negedge clk);
            if (int'(count) != prev) seen = 1'b1;
        end
        if (!seen) begin
            checks++; fails++;
            $display("FAIL R6: count=%0d exp a change within 40 cycles", count);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog: count=%0d exp run complete", count);
        finish_run();
    end

    initial begin
        int v, c, act;
        bit d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, frozen
        for (int i = 0; i < 4; i++) push(0, 0, 4'b0, 1, 1, "R1");
        drain();

        // R2 R11 R12: compare and period selects, up mode with P=4
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd3);
        wr(2'd0, 16'h000B);
        wr(2'd1, 16'd4);
        wr(2'd0, 16'hC008);
        push(0, 0, 4'b0, 1, 1, "R2 R12");
        v = 0;
        for (int i = 1; i <= 11; i++) begin
            v = (v >= 4) ? 0 : v + 1;
            push(v, 0, exp_ev(v, 4, 1), 1, 1, "R2 R11 R12");
        end
        drain();

        // R9: stop after one more step
        wr(2'd0, 16'h0008);
        c = int'(count);
        push(c, 0, 4'b0, 0, 0, "R9");
        v = (c >= 4) ? 0 : c + 1;
        push(v, 0, exp_ev(v, 4, 1), 1, 1, "R9");
        for (int i = 0; i < 4; i++) push(v, 0, 4'b0, 1, 1, "R9");
        drain();

        // R5: frozen mode while run is free
        wr(2'd0, 16'hC00B);
        c = int'(count);
        for (int i = 0; i < 6; i++) push(c, 0, 4'b0, 1, 1, "R5");
        drain();

        // R3: down mode
        wr(2'd0, 16'hC009);
        c = int'(count);
        push(c, 0, 4'b0, 0, 0, "R3");
        v = c;
        for (int i = 0; i < 12; i++) begin
            v = (v == 0) ? 4 : v - 1;
            push(v, 1, exp_ev(v, 4, 0), 1, 1, "R3");
        end
        drain();

        // R4 R11: up-down mode
        wr(2'd0, 16'hC00A);
        c = int'(count);
        d = dir_down;
        push(c, d, 4'b0, 1, 0, "R4");
        v = c;
        for (int i = 0; i < 16; i++) begin
            if (!d) begin
                if (v >= 4) begin d = 1; v = v - 1; end else v = v + 1;
            end else begin
                if (v == 0) begin d = 0; v = 1; end else v = v - 1;
            end
            push(v, d, exp_ev(v, 4, !d), 1, 1, "R4 R11");
        end
        drain();

        // R10: stop at end of the full cycle
        wr(2'd0, 16'h400A);
        c = int'(count);
        d = dir_down;
        push(c, d, 4'b0, 1, 0, "R10");
        v = c;
        for (int i = 0; i < 10; i++) begin
            if (!d) begin
                if (v >= 4) begin d = 1; v = v - 1; end else v = v + 1;
            end else begin
                if (v == 0) begin d = 0; v = 1; end else v = v - 1;
            end
            push(v, d, exp_ev(v, 4, !d), 1, 1, "R10");
            if (v == 0) break;
        end
        for (int i = 0; i < 4; i++) push(v, d, 4'b0, 1, 1, "R10");
        drain();

        // R6: prescale 2^1 * 2 = 4
        wr(2'd0, 16'hC488);
        poll_change();
        c = int'(count);
        push(c, 0, 4'b0, 1, 0, "R6");
        for (int k = 1; k <= 12; k++) begin
            v = (c + k / 4) % 5;
            push(v, 0, (k % 4 == 0) ? exp_ev(v, 4, 1) : 4'b0, 1, 1, "R6");
        end
        drain();

        // R6: prescale 1 * 6 = 6
        wr(2'd0, 16'hC188);
        poll_change();
        c = int'(count);
        push(c, 0, 4'b0, 1, 0, "R6");
        for (int k = 1; k <= 18; k++) begin
            v = (c + k / 6) % 5;
            push(v, 0, (k % 6 == 0) ? exp_ev(v, 4, 1) : 4'b0, 1, 1, "R6");
        end
        drain();

        // R7: shadowed period load at zero
        wr(2'd0, 16'hC000);
        wr(2'd1, 16'd7);
        c = int'(count);
        push(c, 0, 4'b0, 1, 0, "R7");
        v = c;
        act = 4;
        for (int i = 0; i < 20; i++) begin
            v = (v >= act) ? 0 : v + 1;
            push(v, 0, exp_ev(v, act, 1), 1, 1, "R7");
            if (v == 0) act = 7;
        end
        drain();

        // R8: immediate period load
        wr(2'd0, 16'hC008);
        wr(2'd1, 16'd3);
        c = int'(count);
        push(c, 0, 4'b0, 1, 0, "R8");
        v = c;
        for (int i = 0; i < 12; i++) begin
            v = (v >= 3) ? 0 : v + 1;
            push(v, 0, exp_ev(v, 3, 1), 1, 1, "R8");
        end
        drain();

        @(negedge clk);
        finish_run();
    end

endmodule